// File: doc/BRIEF.md
# Boot Block Address Swap Unit

This unit sits on the address path between the processor's boot fetches and the SPI flash controller. When swap mode is active it inverts a selectable group of address bits inside A[23:16], so a fetch aimed at the primary boot block lands on the alternate copy instead. A system can then boot from a freshly written boot block and fall back to the old one without touching the flash layout.

Swap mode has two sources. The first is a pin strap that is sampled once, on the first cycle after reset in which platform power-good is seen high. The second is a write of 1 to the swap bit through a small configuration register port. Either source turns the mode on, and only a full reboot (synchronous reset) turns it off again. Software writes of 0 are ignored. The swap state can be read back as bit 4 of the configuration word at offset 0xDC. The unit also drives the enable for the strap pad's weak pull-down, and releases it once the strap has been sampled. The address remap is purely combinational, so it adds no cycle of latency.

Top module: `bbswap_top`

## Requirements
- R1: While reset is held and in the first cycle after it, the swap state is 0, `strap_pd_en` is 1, a read of offset 0xDC returns 0, and `fetch_addr_o` equals `fetch_addr_i`.
- R2: The strap is sampled on the first rising clock edge after reset at which `pwr_good` is 1. If `strap_in` is 1 there, bit 4 of the word at offset 0xDC reads 1 after that edge.
- R3: If the sample is 0, swap mode stays off. Later changes of `strap_in` and later drops and rises of `pwr_good` have no effect until the next reset.
- R4: `strap_pd_en` is 1 from reset until the edge at which the strap is sampled. It is 0 after that edge and stays 0 until reset.
- R5: The swap state is readable on `cfg_rdata` at bit 4 when `cfg_addr` is 0xDC, with all other bits 0. Every other offset reads 0.
- R6: A write (`cfg_wr_en` = 1) to offset 0xDC with data bit 4 = 1 sets swap mode from the next cycle. A write to any other offset has no effect.
- R7: Once swap mode is set, writes to 0xDC with bit 4 = 0 leave it set. Only reset clears it.
- R8: In swap mode, `blk_size` codes 0, 1, 2 and 3 invert A[16], A[17:16], A[18:16] and A[19:16] respectively. The other bits of A[23:16] pass through unchanged.
- R9: Address bits below A16 and above A23 always pass through. With swap mode off, the output equals the input.
- R10: `fetch_addr_o` follows `fetch_addr_i` and `blk_size` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (full reboot) |
| pwr_good | input | 1 | Platform power-good |
| strap_in | input | 1 | Swap strap pin level |
| strap_pd_en | output | 1 | Strap pad pull-down enable |
| blk_size | input | 2 | Boot block size code (0 = 64 KB, 1 = 128 KB, 2 = 256 KB, 3 = 512 KB) |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| fetch_addr_i | input | 32 | Incoming fetch address |
| fetch_addr_o | output | 32 | Remapped fetch address to the flash controller |

## Verification
The strap sample and a software write to the swap bit can land on the same clock edge, and they must merge into a single sticky state. The bench drives `pwr_good` high and issues a configuration write in the same cycle in two ways. In the first, the strap is 1 and the write carries bit 4 = 0. In the second, the strap is 0 and the write carries bit 4 = 1. In both cases the swap bit must read 1 after that edge, and the address remap must invert A[16].

// File: rtl/bbswap_pkg.sv
package bbswap_pkg;

    localparam int CFG_ADDR_W = 8;
    localparam int CFG_DATA_W = 32;
    localparam int SIZE_W     = 2;

    typedef enum logic [SIZE_W-1:0] {
        BLK_64K  = 2'd0,
        BLK_128K = 2'd1,
        BLK_256K = 2'd2,
        BLK_512K = 2'd3
    } blk_size_e;

    typedef struct packed {
        logic                  en;
        logic [CFG_ADDR_W-1:0] addr;
        logic [CFG_DATA_W-1:0] data;
    } cfg_wr_t;

    // Inversion mask for the swap window: bit k set when k <= size code
    function automatic logic [7:0] win_mask(input blk_size_e sz);
        logic [7:0] m;
        for (int k = 0; k < 8; k++) begin
            m[k] = (k <= int'(sz));
        end
        return m;
    endfunction

endpackage

// File: rtl/bbswap_strap_latch.sv
module bbswap_strap_latch (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    input  logic strap_in,
    output logic sample_now,
    output logic strap_one,
    output logic pd_en
);
    logic armed_q;

    // Strap is sampled once: first edge after reset with power-good seen high
    assign sample_now = armed_q & pwr_good;
    assign strap_one  = sample_now & strap_in;
    assign pd_en      = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
        end else if (sample_now) begin
            armed_q <= 1'b0;
        end
    end

    assert_pd_stays_off_R4: assert property (@(posedge clk) disable iff (rst)
        !pd_en |=> !pd_en);

    assert_pd_release_R4: assert property (@(posedge clk) disable iff (rst)
        (pd_en && pwr_good) |=> !pd_en);

endmodule

// File: rtl/bbswap_cfg_port.sv
module bbswap_cfg_port
    import bbswap_pkg::*;
#(
    parameter logic [CFG_ADDR_W-1:0] CFG_OFFSET = 8'hDC,
    parameter int                    SWAP_BIT   = 4
) (
    input  cfg_wr_t               wr,
    input  logic                  swap_state,
    output logic                  sw_set,
    output logic [CFG_DATA_W-1:0] rdata
);
    logic hit;
    logic data_unused;

    assign hit         = (wr.addr == CFG_OFFSET);
    assign sw_set      = wr.en & hit & wr.data[SWAP_BIT];
    assign data_unused = ^wr.data;

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[SWAP_BIT] = swap_state;
        end
    end

    always_comb begin
        assert_rd_other_zero_R5: assert (hit || rdata == '0);
    end

endmodule

// File: rtl/bbswap_swap_reg.sv
module bbswap_swap_reg (
    input  logic clk,
    input  logic rst,
    input  logic strap_set,
    input  logic sw_set,
    output logic swap_q
);
    // Sticky: either source sets it, only reset clears it
    always_ff @(posedge clk) begin
        if (rst) begin
            swap_q <= 1'b0;
        end else if (strap_set || sw_set) begin
            swap_q <= 1'b1;
        end
    end

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        swap_q |=> swap_q);

    assert_merge_set_R6: assert property (@(posedge clk) disable iff (rst)
        (strap_set || sw_set) |=> swap_q);

endmodule

// File: rtl/bbswap_remap.sv
module bbswap_remap
    import bbswap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_LO = 16,
    parameter int WIN_W  = 8
) (
    input  logic              swap,
    input  blk_size_e         size,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int WIN_HI = WIN_LO + WIN_W - 1;

    logic [7:0] mask;
    assign mask = win_mask(size);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i >= WIN_LO && i <= WIN_HI && (i - WIN_LO) < 8) begin : g_win
            assign addr_out[i] = addr_in[i] ^ (swap & mask[i-WIN_LO]);
        end else begin : g_pass
            assign addr_out[i] = addr_in[i];
        end
    end

    always_comb begin
        assert_low_pass_R9: assert (addr_out[WIN_LO-1:0] == addr_in[WIN_LO-1:0]);
        assert_off_identity_R9: assert (swap || addr_out == addr_in);
    end

endmodule

// File: rtl/bbswap_top.sv
module bbswap_top
    import bbswap_pkg::*;
#(
    parameter int                    ADDR_W     = 32,
    parameter int                    WIN_LO     = 16,
    parameter int                    WIN_W      = 8,
    parameter logic [CFG_ADDR_W-1:0] CFG_OFFSET = 8'hDC,
    parameter int                    SWAP_BIT   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_good,
    input  logic                  strap_in,
    output logic                  strap_pd_en,
    input  logic [SIZE_W-1:0]     blk_size,
    input  logic                  cfg_wr_en,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic [CFG_DATA_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0]     fetch_addr_i,
    output logic [ADDR_W-1:0]     fetch_addr_o
);
    logic    sample_now;
    logic    strap_one;
    logic    sw_set;
    logic    swap_state;
    cfg_wr_t wr;

    assign wr = '{en: cfg_wr_en, addr: cfg_addr, data: cfg_wdata};

    bbswap_strap_latch u_strap (
        .clk        (clk),
        .rst        (rst),
        .pwr_good   (pwr_good),
        .strap_in   (strap_in),
        .sample_now (sample_now),
        .strap_one  (strap_one),
        .pd_en      (strap_pd_en)
    );

    bbswap_cfg_port #(
        .CFG_OFFSET (CFG_OFFSET),
        .SWAP_BIT   (SWAP_BIT)
    ) u_cfg (
        .wr         (wr),
        .swap_state (swap_state),
        .sw_set     (sw_set),
        .rdata      (cfg_rdata)
    );

    bbswap_swap_reg u_swap (
        .clk       (clk),
        .rst       (rst),
        .strap_set (strap_one),
        .sw_set    (sw_set),
        .swap_q    (swap_state)
    );

    bbswap_remap #(
        .ADDR_W (ADDR_W),
        .WIN_LO (WIN_LO),
        .WIN_W  (WIN_W)
    ) u_remap (
        .swap     (swap_state),
        .size     (blk_size_e'(blk_size)),
        .addr_in  (fetch_addr_i),
        .addr_out (fetch_addr_o)
    );

    assert_strap_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (strap_pd_en && pwr_good && strap_in) |=> swap_state);

    assert_late_strap_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!strap_pd_en && !swap_state && !sw_set) |=> !swap_state);

    always_comb begin
        assert_window_lsb_R8: assert (!swap_state ||
            fetch_addr_o[WIN_LO] != fetch_addr_i[WIN_LO]);
    end

    logic sample_unused;
    assign sample_unused = sample_now;

endmodule

// File: tb/bbswap_top_tb_top.sv
`timescale 1ns/100ps
module bbswap_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        pwr_good;
    logic        strap_in;
    logic        strap_pd_en;
    logic [1:0]  blk_size;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] fetch_addr_i;
    logic [31:0] fetch_addr_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bbswap_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .pwr_good     (pwr_good),
        .strap_in     (strap_in),
        .strap_pd_en  (strap_pd_en),
        .blk_size     (blk_size),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .fetch_addr_i (fetch_addr_i),
        .fetch_addr_o (fetch_addr_o)
    );

    // {blk_size, input address, expected output} with swap mode on
    localparam logic [65:0] VEC [6] = '{
        {2'd0, 32'h00FF_1234, 32'h00FE_1234},
        {2'd1, 32'hA5A5_A5A5, 32'hA5A6_A5A5},
        {2'd2, 32'h1200_0000, 32'h1207_0000},
        {2'd3, 32'hFFFF_FFFF, 32'hFFF0_FFFF},
        {2'd3, 32'h0013_0000, 32'h001C_0000},
        {2'd0, 32'h0001_0000, 32'h0000_0000}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic read_swap(input string req, input logic [31:0] exp);
        cfg_addr = 8'hDC;
        #0.5;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1; pwr_good = 1'b0; strap_in = 1'b0; cfg_wr_en = 1'b0;
        cfg_addr = 8'h00; cfg_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    initial begin
        blk_size = 2'd0; fetch_addr_i = 32'h0001_ABCD;
        do_reset();
        // R1 reset state
        chk("R1 pd_en", {31'b0, strap_pd_en}, 32'd1);
        read_swap("R1 swap bit", 32'h0);
        chk("R1 addr pass", fetch_addr_o, 32'h0001_ABCD);

        // R3/R4: strap sampled as 0
        tick();
        chk("R4 pd_en before sample", {31'b0, strap_pd_en}, 32'd1);
        pwr_good = 1'b1;
        tick();
        chk("R4 pd_en released", {31'b0, strap_pd_en}, 32'd0);
        read_swap("R3 strap 0 off", 32'h0);
        strap_in = 1'b1; pwr_good = 1'b0;
        tick();
        pwr_good = 1'b1;
        tick(); tick();
        read_swap("R3 late strap ignored", 32'h0);
        chk("R4 pd_en stays low", {31'b0, strap_pd_en}, 32'd0);
        blk_size = 2'd3; fetch_addr_i = 32'hFFFF_FFFF;
        #0.5;
        chk("R9 off identity", fetch_addr_o, 32'hFFFF_FFFF);

        // R6: write to another offset has no effect
        cfg_wr_en = 1'b1; cfg_addr = 8'hD8; cfg_wdata = 32'h10;
        tick();
        cfg_wr_en = 1'b0;
        read_swap("R6 other offset ignored", 32'h0);
        cfg_addr = 8'hDC; cfg_wdata = 32'hFFFF_FFEF; cfg_wr_en = 1'b1;
        tick();
        cfg_wr_en = 1'b0;
        read_swap("R6 bit4 zero no set", 32'h0);
        // R6: set through the port
        cfg_wr_en = 1'b1; cfg_wdata = 32'h10;
        #0.5;
        chk("R6 not before edge", cfg_rdata, 32'h0);
        tick();
        cfg_wr_en = 1'b0;
        read_swap("R6 sw set", 32'h10);
        cfg_addr = 8'hDD;
        #0.5;
        chk("R5 other offset reads 0", cfg_rdata, 32'h0);
        // R7: write of 0 ignored
        cfg_addr = 8'hDC; cfg_wdata = 32'h0; cfg_wr_en = 1'b1;
        tick(); tick();
        cfg_wr_en = 1'b0;
        read_swap("R7 zero write ignored", 32'h10);

        // R8/R9/R10: table walk, combinational, no clock edge between
        @(negedge clk);
        foreach (VEC[i]) begin
            blk_size     = VEC[i][65:64];
            fetch_addr_i = VEC[i][63:32];
            #0.3;
            chk("R8 R9 R10 remap", fetch_addr_o, VEC[i][31:0]);
        end

        // R7: reset clears; R2 strap 1 captured
        do_reset();
        read_swap("R7 reboot clears", 32'h0);
        strap_in = 1'b1; pwr_good = 1'b1;
        #0.5;
        chk("R2 not before edge", cfg_rdata, 32'h0);
        tick();
        strap_in = 1'b0;
        read_swap("R2 strap capture", 32'h10);
        blk_size = 2'd1; fetch_addr_i = 32'h0000_0000;
        #0.5;
        chk("R8 size1 after strap", fetch_addr_o, 32'h0003_0000);

        // Concurrent: strap 1 with a zero write on the same edge
        do_reset();
        strap_in = 1'b1; pwr_good = 1'b1;
        cfg_wr_en = 1'b1; cfg_addr = 8'hDC; cfg_wdata = 32'h0;
        tick();
        cfg_wr_en = 1'b0;
        read_swap("R2 R7 strap with zero write", 32'h10);
        blk_size = 2'd0; fetch_addr_i = 32'h1234_5678;
        #0.5;
        chk("R8 concurrent remap", fetch_addr_o, 32'h1235_5678);

        // Concurrent: strap 0 with a set write on the same edge
        do_reset();
        strap_in = 1'b0; pwr_good = 1'b1;
        cfg_wr_en = 1'b1; cfg_addr = 8'hDC; cfg_wdata = 32'h10;
        tick();
        cfg_wr_en = 1'b0;
        read_swap("R3 R6 strap 0 with set write", 32'h10);
        chk("R4 pd_en after merge", {31'b0, strap_pd_en}, 32'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule